// File: doc/BRIEF.md
# Per-page receive flag register

This block holds one status flag for each receive page of a network controller. There are 31 pages, numbered 1 to 31. The host sees the flags through two 16-bit registers. Register 0 holds pages 1 to 15 and register 1 holds pages 16 to 31. The host clears flags by writing ones to them, so writing back a value it has just read clears only the flags it saw as set.

The block works in one of two receive modes. In free-format mode, a flag set to 1 means the page has completed a reception and is blocked from receiving again. The flag clears when the host writes a one to its bit. It can also clear when the host reads the last byte of that page, if auto-clear is enabled. In remote-buffer mode, a flag set to 1 means a packet for that page arrived within the current monitoring window. All flags clear together when the command register is written with the warning-clear code, or when the monitor reports a good result.

When the global receive-inhibit input is released, every flag is forced to 1 in either mode. An any-flag-set output gives the OR of all flags, one cycle behind the flags.

Top module: `rx_page_flags`

## Requirements
- R1: Page p is at bit p mod 16 of register p div 16. `hostAddr` = 0 selects register 0 and `hostAddr` = 1 selects register 1. `hostRdData` shows the selected register in the same cycle, without a clock edge.
- R2: A pulse on `rxDone[p]` (p from 1 to 31) sets flag p at the next rising clock edge, in either mode.
- R3: In free-format mode, a host write clears exactly the flags of the addressed register whose written bit is 1. Flags whose written bit is 0, and the flags of the other register, keep their values.
- R4: When a set event and any clear source hit the same flag in the same cycle, the flag ends up at 1.
- R5: In free-format mode with `autoClrN` = 0, a pulse on `lastRead[p]` clears flag p. With `autoClrN` = 1, `lastRead` has no effect.
- R6: A change of `rxInhibit` from 1 to 0 sets all 31 flags at the next edge, in either mode. This overrides any clear in that same cycle.
- R7: In remote-buffer mode (`modeRemote` = 1), `cmdWrEn` with `cmdWrData` = 8'h0A clears every flag. Any other command code leaves the flags unchanged.
- R8: In remote-buffer mode, a pulse on `monOk` clears every flag.
- R9: In remote-buffer mode, host writes and `lastRead` pulses do not change any flag.
- R10: Bit 0 of register 0 always reads 0. It is not affected by host writes or by `rxDone[0]`.
- R11: `anySet` equals the OR of all flags as they were one clock earlier.
- R12: After reset, all flags and `anySet` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeRemote | input | 1 | 0 selects free-format mode, 1 selects remote-buffer mode |
| rxInhibit | input | 1 | Global receive inhibit. A 1-to-0 change sets all flags |
| autoClrN | input | 1 | Active-low enable for clearing a flag on last-byte readout |
| rxDone | input | 32 | Per-page receive-complete pulses. Bit 0 is unused |
| lastRead | input | 32 | Per-page last-byte-readout pulses. Bit 0 is unused |
| monOk | input | 1 | Pulse at the end of a monitoring window when the result is OK |
| cmdWrEn | input | 1 | Command register write strobe |
| cmdWrData | input | 8 | Command code written with `cmdWrEn` |
| hostAddr | input | 1 | Flag register select |
| hostWrEn | input | 1 | Host write strobe (write-one-to-clear) |
| hostWrData | input | 16 | Host write data |
| hostRdData | output | 16 | Contents of the selected flag register |
| anySet | output | 1 | Registered OR of all flags |

## Verification
The bench targets the following corner cases, and the failure each one would expose:

- **Set and clear in the same cycle.** A design that let the clear win would drop a reception.
- **Write-back after a new set.** The host writes back a stale read value after a page has been set since the read. A design that cleared the whole register would erase that new flag.
- **Clears that the mode should block.** Host writes and last-byte reads in remote mode, and last-byte reads with auto-clear disabled. A design that gated these wrongly would clear flags it should not touch.
- **Inhibit release, bit 0 and `anySet` timing.** Inhibit release coincides with a host clear. A broken bit 0 would read back 1. An `anySet` that is unregistered or two cycles late would be off by one cycle.

// File: rtl/rxf_pkg.sv
package rxf_pkg;
  localparam int REG_W    = 16;
  localparam int NUM_REGS = 2;
  localparam int PAGES    = REG_W * NUM_REGS;
  localparam int ADDR_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

  typedef struct packed {
    logic                forceAll;   // inhibit released: set every flag
    logic                remoteClr;  // remote mode: clear every flag
    logic                autoClr;    // free mode: last-byte readout clears
    logic [NUM_REGS-1:0] hostClrSel; // free mode: register being W1C-written
  } ctrlStrobes_t;
endpackage

// File: rtl/rxf_ctrl.sv
module rxf_ctrl
  import rxf_pkg::*;
#(
  parameter int                CMD_W    = 8,
  parameter logic [CMD_W-1:0]  CLR_CODE = 8'h0A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeRemote,
  input  logic              rxInhibit,
  input  logic              autoClrN,
  input  logic              monOk,
  input  logic              cmdWrEn,
  input  logic [CMD_W-1:0]  cmdWrData,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  output ctrlStrobes_t      strobes
);

  logic prevInhibit;
  logic clrCmdHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevInhibit <= 1'b0;
    else       prevInhibit <= rxInhibit;
  end

  assign clrCmdHit = cmdWrEn && (cmdWrData == CLR_CODE);

  always_comb begin
    strobes.forceAll  = prevInhibit & ~rxInhibit;
    strobes.remoteClr = modeRemote & (clrCmdHit | monOk);
    strobes.autoClr   = ~modeRemote & ~autoClrN;
  end

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
    assign strobes.hostClrSel[r] = ~modeRemote & hostWrEn & (hostAddr == ADDR_W'(r));
  end

  // R6
  release_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.forceAll |=> !strobes.forceAll);

endmodule

// File: rtl/rxf_datapath.sv
module rxf_datapath
  import rxf_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strobes,
  input  logic [PAGES-1:0]  rxDone,
  input  logic [PAGES-1:0]  lastRead,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic [REG_W-1:0]  hostWrData,
  output logic [REG_W-1:0]  hostRdData,
  output logic              anySet
);

  logic [PAGES-1:0] flagQ;
  logic [PAGES-1:0] flagNext;
  logic [PAGES-1:0] hostClrVec;
  logic [PAGES-1:0] clrVec;
  logic             unusedBits;

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_hostclr
    assign hostClrVec[r*REG_W +: REG_W] = strobes.hostClrSel[r] ? hostWrData : '0;
  end

  assign clrVec = hostClrVec
                | (strobes.autoClr ? lastRead : '0)
                | {PAGES{strobes.remoteClr}};

  for (genvar p = 0; p < PAGES; p++) begin : g_page
    if (p == 0) begin : g_none
      assign flagNext[p] = 1'b0;
    end else begin : g_flag
      // set sources dominate every clear source
      assign flagNext[p] = strobes.forceAll | rxDone[p] | (flagQ[p] & ~clrVec[p]);
    end
  end

  assign unusedBits = ^{rxDone[0], lastRead[0], clrVec[0]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagQ  <= '0;
      anySet <= 1'b0;
    end else begin
      flagQ  <= flagNext;
      anySet <= |flagQ;
    end
  end

  assign hostRdData = flagQ[int'(hostAddr)*REG_W +: REG_W];

  // R6
  inhibit_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.forceAll |=> (flagQ[PAGES-1:1] == '1));

  // R4
  set_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxDone[PAGES-1:1] != '0) |=>
      ((flagQ[PAGES-1:1] & $past(rxDone[PAGES-1:1])) == $past(rxDone[PAGES-1:1])));

  // R7
  remote_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.remoteClr && !strobes.forceAll && rxDone[PAGES-1:1] == '0) |=> (flagQ == '0));

  // R11
  any_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> (anySet == $past(|flagQ)));

  // R3
  no_spurious_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (clrVec[PAGES-1:1] == '0) |=> (($past(flagQ) & ~flagQ) == '0));

  // R10
  page_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hostAddr == '0) |-> (hostRdData[0] == 1'b0));

endmodule

// File: rtl/rx_page_flags.sv
module rx_page_flags
  import rxf_pkg::*;
#(
  parameter int               CMD_W    = 8,
  parameter logic [CMD_W-1:0] CLR_CODE = 8'h0A
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              modeRemote,
  input  logic              rxInhibit,
  input  logic              autoClrN,
  input  logic [PAGES-1:0]  rxDone,
  input  logic [PAGES-1:0]  lastRead,
  input  logic              monOk,
  input  logic              cmdWrEn,
  input  logic [CMD_W-1:0]  cmdWrData,
  input  logic [ADDR_W-1:0] hostAddr,
  input  logic              hostWrEn,
  input  logic [REG_W-1:0]  hostWrData,
  output logic [REG_W-1:0]  hostRdData,
  output logic              anySet
);

  ctrlStrobes_t strobes;

  rxf_ctrl #(
    .CMD_W    (CMD_W),
    .CLR_CODE (CLR_CODE)
  ) i_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .modeRemote (modeRemote),
    .rxInhibit  (rxInhibit),
    .autoClrN   (autoClrN),
    .monOk      (monOk),
    .cmdWrEn    (cmdWrEn),
    .cmdWrData  (cmdWrData),
    .hostAddr   (hostAddr),
    .hostWrEn   (hostWrEn),
    .strobes    (strobes)
  );

  rxf_datapath i_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .rxDone     (rxDone),
    .lastRead   (lastRead),
    .hostAddr   (hostAddr),
    .hostWrData (hostWrData),
    .hostRdData (hostRdData),
    .anySet     (anySet)
  );

endmodule

// File: tb/test_rx_page_flags.sv
`timescale 1ns/1ps
module test_rx_page_flags;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        modeRemote = 1'b0;
  logic        rxInhibit = 1'b0;
  logic        autoClrN = 1'b1;
  logic [31:0] rxDone = '0;
  logic [31:0] lastRead = '0;
  logic        monOk = 1'b0;
  logic        cmdWrEn = 1'b0;
  logic [7:0]  cmdWrData = '0;
  logic [0:0]  hostAddr = '0;
  logic        hostWrEn = 1'b0;
  logic [15:0] hostWrData = '0;
  logic [15:0] hostRdData;
  logic        anySet;

  int testCount = 0;
  int failCount = 0;

  always #2.5 clk = ~clk;

  rx_page_flags i_rx_page_flags (
    .clk(clk), .rstN(rstN), .modeRemote(modeRemote), .rxInhibit(rxInhibit),
    .autoClrN(autoClrN), .rxDone(rxDone), .lastRead(lastRead), .monOk(monOk),
    .cmdWrEn(cmdWrEn), .cmdWrData(cmdWrData), .hostAddr(hostAddr),
    .hostWrEn(hostWrEn), .hostWrData(hostWrData), .hostRdData(hostRdData),
    .anySet(anySet)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic readReg(input int a, output logic [15:0] d);
    hostAddr = a[0];
    #1 d = hostRdData;
  endtask

  task automatic writeReg(input int a, input logic [15:0] d);
    hostAddr = a[0];
    hostWrData = d;
    hostWrEn = 1'b1;
    tick();
    hostWrEn = 1'b0;
  endtask

  task automatic pulseRx(input logic [31:0] m);
    rxDone = m;
    tick();
    rxDone = '0;
  endtask

  task automatic clearAll();
    writeReg(0, 16'hFFFF);
    writeReg(1, 16'hFFFF);
  endtask

  task automatic testReset();
    logic [15:0] d;
    readReg(0, d); check("R12 low after reset", d, 0);
    readReg(1, d); check("R12 high after reset", d, 0);
    check("R12 anySet after reset", anySet, 0);
  endtask

  task automatic testSetMap();
    logic [15:0] d;
    pulseRx(32'h0001_0008);
    check("R11 anySet lags flags", anySet, 0);
    readReg(0, d); check("R2 page3 in low reg", d, 16'h0008);
    readReg(1, d); check("R1 page16 at high bit0", d, 16'h0001);
    tick();
    check("R11 anySet rises", anySet, 1);
    clearAll();
    check("R11 anySet still high one cycle", anySet, 1);
    tick();
    check("R11 anySet falls", anySet, 0);
  endtask

  task automatic testW1C();
    logic [15:0] seen, d;
    pulseRx(32'h0000_0028);
    readReg(0, seen); check("R3 read pages 3,5", seen, 16'h0028);
    pulseRx(32'h0000_0080);
    writeReg(0, seen);
    readReg(0, d); check("R3 write-back keeps new flag", d, 16'h0080);
    writeReg(1, 16'hFFFF);
    readReg(0, d); check("R1 high write leaves low reg", d, 16'h0080);
    clearAll();
  endtask

  task automatic testSetWins();
    logic [15:0] d;
    pulseRx(32'h0000_0200);
    rxDone = 32'h0000_0200;
    writeReg(0, 16'h0200);
    rxDone = '0;
    readReg(0, d); check("R4 set beats host clear", d, 16'h0200);
    writeReg(0, 16'h0200);
    readReg(0, d); check("R3 host clear alone", d, 0);
  endtask

  task automatic testBit0();
    logic [15:0] d;
    pulseRx(32'h0000_0001);
    readReg(0, d); check("R10 rxDone[0] ignored", d, 0);
    writeReg(0, 16'h0001);
    readReg(0, d); check("R10 bit0 reads zero", d, 0);
    tick();
    check("R10 anySet stays low", anySet, 0);
  endtask

  task automatic testAutoClr();
    logic [15:0] d;
    pulseRx(32'h0010_0010);
    autoClrN = 1'b1;
    lastRead = 32'h0010_0010; tick(); lastRead = '0;
    readReg(0, d); check("R5 disabled auto-clear", d, 16'h0010);
    autoClrN = 1'b0;
    lastRead = 32'h0000_0010; tick(); lastRead = '0;
    readReg(0, d); check("R5 auto-clear page4", d, 0);
    readReg(1, d); check("R5 auto-clear only that page", d, 16'h0010);
    lastRead = 32'h0010_0000; tick(); lastRead = '0;
    readReg(1, d); check("R5 auto-clear page20", d, 0);
    autoClrN = 1'b1;
  endtask

  task automatic testInhibit();
    logic [15:0] d;
    rxInhibit = 1'b1; tick(); tick();
    readReg(0, d); check("R6 no set while inhibited", d, 0);
    rxInhibit = 1'b0;
    writeReg(0, 16'hFFFF);
    readReg(0, d); check("R6 release sets low", d, 16'hFFFE);
    readReg(1, d); check("R6 release sets high", d, 16'hFFFF);
    clearAll();
    modeRemote = 1'b1;
    rxInhibit = 1'b1; tick();
    rxInhibit = 1'b0; tick();
    readReg(1, d); check("R6 release in remote mode", d, 16'hFFFF);
    cmdWrData = 8'h0A; cmdWrEn = 1'b1; tick(); cmdWrEn = 1'b0;
    modeRemote = 1'b0;
  endtask

  task automatic testRemote();
    logic [15:0] d;
    modeRemote = 1'b1;
    pulseRx(32'h0002_0004);
    readReg(0, d); check("R2 set in remote mode", d, 16'h0004);
    writeReg(0, 16'hFFFF);
    readReg(0, d); check("R9 host write ignored", d, 16'h0004);
    autoClrN = 1'b0;
    lastRead = '1; tick(); lastRead = '0;
    autoClrN = 1'b1;
    readReg(0, d); check("R9 last read ignored", d, 16'h0004);
    cmdWrData = 8'h0B; cmdWrEn = 1'b1; tick(); cmdWrEn = 1'b0;
    readReg(1, d); check("R7 other code ignored", d, 16'h0002);
    cmdWrData = 8'h0A; cmdWrEn = 1'b1; tick(); cmdWrEn = 1'b0;
    readReg(0, d); check("R7 clear code low", d, 0);
    readReg(1, d); check("R7 clear code high", d, 0);
    pulseRx(32'h8000_0004);
    monOk = 1'b1; tick(); monOk = 1'b0;
    readReg(1, d); check("R8 monitor OK clears", d, 0);
    rxDone = 32'h0000_0004; monOk = 1'b1; tick(); monOk = 1'b0; rxDone = '0;
    readReg(0, d); check("R4 set beats monitor clear", d, 16'h0004);
    monOk = 1'b1; tick(); monOk = 1'b0;
    modeRemote = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failCount++;
    testCount++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testSetMap();
    testW1C();
    testSetWins();
    testBit0();
    testAutoClr();
    testInhibit();
    testRemote();
    $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule